// File: doc/BRIEF.md
# Address Translation Sequencing Controller

This block takes one processor access per cycle and decides how its physical address is produced. It receives a logical address, a 3-bit function code, a read/write flag, hit flags from the instruction and data caches, and the results of two transparent-window comparators. It then resolves the access through one of four paths, in fixed priority order.

The first path is a pass-through for CPU-space accesses. The second completes a read that one of the caches already holds. The third is an untranslated pass-through when a transparent window matches. The fourth is a lookup in a small fully associative translation cache whose entries are tagged by logical page and function code.

On a translation-cache miss, the controller aborts the current cycle and asks an external walker for the physical page. While it waits, it stalls new accesses. When the walker answers, the controller fills an entry, including the walker's bus-error flag, and repeats the lookup. An entry filled with a bus error raises an exception whenever it is hit, instead of starting a memory cycle.

Top module: `xlat_seq_ctrl`

## Requirements
- R1: With the function code all ones (3'b111), the next cycle shows `mem_strobe`=1 and `acc_done`=1, and `phys_addr` equals the logical address. No abort occurs, whatever the cache and window inputs are.
- R2: On a read (`acc_rd`=1) with `icache_hit` or `dcache_hit` set and a function code other than 3'b111, the next cycle shows `acc_done`=1 with no strobe and no abort. `phys_addr` keeps its previous value, even if a transparent window also matches.
- R3: On a write (`acc_rd`=0), the cache-hit inputs have no effect, and the access falls through to the lower-priority checks.
- R4: When either transparent comparator matches (and R1 and R2 do not apply), the next cycle strobes with `phys_addr` equal to the logical address. This holds even if the translation cache holds a different mapping for that page.
- R5: A translation-cache hit requires both the page number (address bits 31:12) and the function code to match. A hit strobes the next cycle with `phys_addr` = {stored page, address bits 11:0}, and no walk is started.
- R6: A miss pulses `cyc_abort` for one cycle and starts a walk. From the next cycle, `walk_req` is high, with `walk_vpn` and `walk_fc` taken from the access. `walk_req` stays high until the cycle in which `walk_ack` is sampled.
- R7: In the cycle after `walk_ack` is sampled, `walk_req` is low and no strobe is shown. In the cycle after that, the retried lookup hits the new entry and strobes with {`walk_ppn`, offset}.
- R8: If the walk returned `walk_berr`=1, every hit on that entry, including the retry itself, gives `cyc_abort`, `berr_exc` and `acc_done` with no strobe.
- R9: `acc_ready` is low from the miss until the retry completes. Accesses presented during that time are ignored and produce no output pulse.
- R10: A one-cycle `flush` invalidates every entry, so a page that hit before the flush misses afterwards.
- R11: The cache holds 8 entries. A fill takes the lowest-numbered free entry. When no entry is free, it takes the entry named by a round-robin pointer, which starts at entry 0 after reset or flush and advances after each such replacement.
- R12: After reset, `acc_ready`=1, and all output pulses and `walk_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all translation entries |
| acc_valid | input | 1 | Access presented this cycle |
| acc_ready | output | 1 | Controller can accept an access |
| acc_addr | input | 32 | Logical address |
| acc_fc | input | 3 | Function code |
| acc_rd | input | 1 | 1 = read, 0 = write |
| icache_hit | input | 1 | Instruction cache holds the item |
| dcache_hit | input | 1 | Data cache holds the item |
| tt0_match | input | 1 | Transparent window 0 matches |
| tt1_match | input | 1 | Transparent window 1 matches |
| walk_req | output | 1 | Table walk request |
| walk_vpn | output | 20 | Logical page to walk |
| walk_fc | output | 3 | Function code of walked access |
| walk_ack | input | 1 | Walk result valid |
| walk_ppn | input | 20 | Physical page from walk |
| walk_berr | input | 1 | Bus error seen during walk |
| mem_strobe | output | 1 | Memory cycle start pulse |
| phys_addr | output | 32 | Physical address, held between strobes |
| cyc_abort | output | 1 | Current cycle aborted pulse |
| berr_exc | output | 1 | Bus-error exception pulse |
| acc_done | output | 1 | Access finished pulse |

## Verification
Every access reports its outcome exactly one cycle after acceptance, so a fault in the priority chain or the tag compare shows up immediately. It appears as a wrong pulse pattern or a wrong `phys_addr` on that cycle. A corrupted valid bit, tag or victim pointer stays hidden until the affected page is touched again. It then shows as an unexpected abort or a missing one, or as a translation to a stale page. For this reason the replacement order is checked by refilling past capacity and probing the survivor and the evicted page. A broken walk sequence shows as `walk_req` dropping early or staying high, or as the retry strobe arriving in the wrong cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_RETRY = 2'd2
  } seq_st_t;

  typedef enum logic [2:0] {
    RES_BYPASS = 3'd0,
    RES_CACHE  = 3'd1,
    RES_TRANSP = 3'd2,
    RES_HIT    = 3'd3,
    RES_BERR   = 3'd4,
    RES_MISS   = 3'd5
  } res_t;

endpackage

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               fill,
  input  logic [ENTRIES-1:0] vld,
  output logic [IDX_W-1:0]   victim
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest-numbered free slot wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    victim = any_free ? free_idx : rr_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rr_ptr <= '0;
    end else if (fill && !any_free) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int FC_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [FC_W-1:0]  lk_fc,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_berr,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [FC_W-1:0]  wr_fc,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_berr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_vpn [ENTRIES];
  logic [FC_W-1:0]    tag_fc  [ENTRIES];
  logic [PPN_W-1:0]   dat_ppn [ENTRIES];
  logic [ENTRIES-1:0] dat_berr;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   victim;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld[g] && (tag_vpn[g] == lk_vpn) && (tag_fc[g] == lk_fc);
    end
  endgenerate

  // a page/fc pair is filled only after a miss, so at most one slot matches
  always_comb begin
    lk_hit  = |match;
    lk_ppn  = '0;
    lk_berr = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_ppn  = lk_ppn | dat_ppn[i];
        lk_berr = lk_berr | dat_berr[i];
      end
    end
  end

  xlat_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .fill   (wr_en),
    .vld    (vld),
    .victim (victim)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[victim] <= 1'b1;
    end
  end

  // payload carries no reset; only the valid bits qualify it
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_vpn[victim]  <= wr_vpn;
      tag_fc[victim]   <= wr_fc;
      dat_ppn[victim]  <= wr_ppn;
      dat_berr[victim] <= wr_berr;
    end
  end

endmodule

// File: rtl/xlat_resolver.sv
module xlat_resolver
  import xlat_pkg::*;
#(
  parameter int FC_W = 3
) (
  input  logic [FC_W-1:0] fc,
  input  logic            rd,
  input  logic            ic_hit,
  input  logic            dc_hit,
  input  logic            tt0,
  input  logic            tt1,
  input  logic            tlb_hit,
  input  logic            tlb_berr,
  input  logic            tlb_only,
  output res_t            res
);

  always_comb begin
    if (!tlb_only && (fc == {FC_W{1'b1}})) begin
      res = RES_BYPASS;
    end else if (!tlb_only && rd && (ic_hit || dc_hit)) begin
      res = RES_CACHE;
    end else if (!tlb_only && (tt0 || tt1)) begin
      res = RES_TRANSP;
    end else if (tlb_hit) begin
      res = tlb_berr ? RES_BERR : RES_HIT;
    end else begin
      res = RES_MISS;
    end
  end

endmodule

// File: rtl/xlat_seq_ctrl.sv
module xlat_seq_ctrl
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8,
  parameter int FC_W      = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        acc_valid,
  output logic                        acc_ready,
  input  logic [ADDR_W-1:0]           acc_addr,
  input  logic [FC_W-1:0]             acc_fc,
  input  logic                        acc_rd,
  input  logic                        icache_hit,
  input  logic                        dcache_hit,
  input  logic                        tt0_match,
  input  logic                        tt1_match,
  output logic                        walk_req,
  output logic [ADDR_W-PAGE_BITS-1:0] walk_vpn,
  output logic [FC_W-1:0]             walk_fc,
  input  logic                        walk_ack,
  input  logic [ADDR_W-PAGE_BITS-1:0] walk_ppn,
  input  logic                        walk_berr,
  output logic                        mem_strobe,
  output logic [ADDR_W-1:0]           phys_addr,
  output logic                        cyc_abort,
  output logic                        berr_exc,
  output logic                        acc_done
);

  localparam int VPN_W = ADDR_W - PAGE_BITS;

  seq_st_t           state;
  logic [ADDR_W-1:0] sav_addr;
  logic [FC_W-1:0]   sav_fc;

  logic [ADDR_W-1:0] lk_addr;
  logic [FC_W-1:0]   lk_fc;
  logic              retrying;
  logic              take;
  logic              fill;
  logic              tlb_hit;
  logic              tlb_berr;
  logic [VPN_W-1:0]  tlb_ppn;
  res_t              res;

  assign retrying  = (state == ST_RETRY);
  assign acc_ready = (state == ST_IDLE);
  assign take      = (acc_ready && acc_valid) || retrying;
  assign fill      = (state == ST_WALK) && walk_ack;
  assign lk_addr   = retrying ? sav_addr : acc_addr;
  assign lk_fc     = retrying ? sav_fc : acc_fc;
  assign walk_vpn  = sav_addr[ADDR_W-1:PAGE_BITS];
  assign walk_fc   = sav_fc;

  xlat_tag_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (VPN_W),
    .FC_W    (FC_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .lk_vpn  (lk_addr[ADDR_W-1:PAGE_BITS]),
    .lk_fc   (lk_fc),
    .lk_hit  (tlb_hit),
    .lk_ppn  (tlb_ppn),
    .lk_berr (tlb_berr),
    .wr_en   (fill),
    .wr_vpn  (sav_addr[ADDR_W-1:PAGE_BITS]),
    .wr_fc   (sav_fc),
    .wr_ppn  (walk_ppn),
    .wr_berr (walk_berr)
  );

  xlat_resolver #(.FC_W(FC_W)) u_res (
    .fc       (lk_fc),
    .rd       (acc_rd),
    .ic_hit   (icache_hit),
    .dc_hit   (dcache_hit),
    .tt0      (tt0_match),
    .tt1      (tt1_match),
    .tlb_hit  (tlb_hit),
    .tlb_berr (tlb_berr),
    .tlb_only (retrying),
    .res      (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sav_addr   <= '0;
      sav_fc     <= '0;
      walk_req   <= 1'b0;
      mem_strobe <= 1'b0;
      phys_addr  <= '0;
      cyc_abort  <= 1'b0;
      berr_exc   <= 1'b0;
      acc_done   <= 1'b0;
    end else begin
      mem_strobe <= 1'b0;
      cyc_abort  <= 1'b0;
      berr_exc   <= 1'b0;
      acc_done   <= 1'b0;
      case (state)
        ST_IDLE, ST_RETRY: begin
          if (take) begin
            sav_addr <= lk_addr;
            sav_fc   <= lk_fc;
            state    <= ST_IDLE;
            case (res)
              RES_BYPASS, RES_TRANSP: begin
                phys_addr  <= lk_addr;
                mem_strobe <= 1'b1;
                acc_done   <= 1'b1;
              end
              RES_CACHE: begin
                acc_done <= 1'b1;
              end
              RES_HIT: begin
                phys_addr  <= {tlb_ppn, lk_addr[PAGE_BITS-1:0]};
                mem_strobe <= 1'b1;
                acc_done   <= 1'b1;
              end
              RES_BERR: begin
                cyc_abort <= 1'b1;
                berr_exc  <= 1'b1;
                acc_done  <= 1'b1;
              end
              RES_MISS: begin
                cyc_abort <= 1'b1;
                walk_req  <= 1'b1;
                state     <= ST_WALK;
              end
              default: ;
            endcase
          end
        end
        ST_WALK: begin
          if (walk_ack) begin
            walk_req <= 1'b0;
            state    <= ST_RETRY;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlat_seq_chk.sv
module xlat_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int FC_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [FC_W-1:0]   acc_fc,
  input logic              walk_req,
  input logic              walk_ack,
  input logic              mem_strobe,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              cyc_abort,
  input logic              berr_exc,
  input logic              acc_done
);

  p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_ready && acc_valid && acc_fc == {FC_W{1'b1}})
      |=> (mem_strobe && !cyc_abort && phys_addr == $past(acc_addr)));

  p_strobe_done_r4: assert property (@(posedge clk) disable iff (rst)
    mem_strobe |-> (acc_done && !cyc_abort));

  p_abort_starts_walk_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_req) |-> cyc_abort);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_ack) |=> walk_req);

  p_req_release_r7: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_ack) |=> (!walk_req && !mem_strobe && !acc_done));

  p_exc_aborts_r8: assert property (@(posedge clk) disable iff (rst)
    berr_exc |-> (cyc_abort && acc_done && !mem_strobe));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> !acc_ready);

endmodule

bind xlat_seq_ctrl xlat_seq_chk #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_addr   (acc_addr),
  .acc_fc     (acc_fc),
  .walk_req   (walk_req),
  .walk_ack   (walk_ack),
  .mem_strobe (mem_strobe),
  .phys_addr  (phys_addr),
  .cyc_abort  (cyc_abort),
  .berr_exc   (berr_exc),
  .acc_done   (acc_done)
);

// File: tb/tb_xlat_seq_ctrl.sv
module tb_xlat_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_fc = '0;
  logic        acc_rd = 1'b0;
  logic        icache_hit = 1'b0, dcache_hit = 1'b0;
  logic        tt0_match = 1'b0, tt1_match = 1'b0;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [2:0]  walk_fc;
  logic        walk_ack = 1'b0;
  logic [19:0] walk_ppn = '0;
  logic        walk_berr = 1'b0;
  logic        mem_strobe, cyc_abort, berr_exc, acc_done;
  logic [31:0] phys_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xlat_seq_ctrl dut (
    .clk(clk), .rst(rst), .flush(flush), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_fc(acc_fc), .acc_rd(acc_rd), .icache_hit(icache_hit),
    .dcache_hit(dcache_hit), .tt0_match(tt0_match), .tt1_match(tt1_match),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_fc(walk_fc), .walk_ack(walk_ack),
    .walk_ppn(walk_ppn), .walk_berr(walk_berr), .mem_strobe(mem_strobe),
    .phys_addr(phys_addr), .cyc_abort(cyc_abort), .berr_exc(berr_exc), .acc_done(acc_done)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  fc;
    logic        rd, ic, dc, t0, t1;
    logic        strobe;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_2345, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R1 bypass beats all
    '{32'h0040_0010, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 icache beats window
    '{32'h0040_0020, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 dcache
    '{32'h0050_0ABC, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 write ignores cache, R4
    '{32'h0060_0004, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 window 1
    '{32'hFFFF_F000, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}   // R1 write
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one access for one cycle; returns at the negedge where its outcome is visible
  task automatic access(input logic [31:0] a, input logic [2:0] f, input logic rd,
                        input logic ic, input logic dc, input logic t0, input logic t1);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_fc = f; acc_rd = rd;
    icache_hit = ic; dcache_hit = dc; tt0_match = t0; tt1_match = t1;
    @(negedge clk);
    acc_valid = 1'b0; icache_hit = 1'b0; dcache_hit = 1'b0;
    tt0_match = 1'b0; tt1_match = 1'b0;
  endtask

  // answer an outstanding walk; returns where the retry outcome is visible
  task automatic serve(input logic [19:0] ppn, input logic be, input int hold);
    for (int i = 0; i < hold; i++) begin
      check("R6 req held", {31'd0, walk_req}, 32'd1);
      @(negedge clk);
    end
    walk_ack = 1'b1; walk_ppn = ppn; walk_berr = be;
    @(negedge clk);
    walk_ack = 1'b0; walk_berr = 1'b0;
    check("R7 req dropped", {31'd0, walk_req}, 32'd0);
    check("R7 no strobe yet", {31'd0, mem_strobe}, 32'd0);
    @(negedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    logic [31:0] last_phys;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 ready", {31'd0, acc_ready}, 32'd1);
    check("R12 walk_req", {31'd0, walk_req}, 32'd0);
    check("R12 pulses", {28'd0, mem_strobe, cyc_abort, berr_exc, acc_done}, 32'd0);
    last_phys = phys_addr;

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].addr, VECS[v].fc, VECS[v].rd, VECS[v].ic, VECS[v].dc,
             VECS[v].t0, VECS[v].t1);
      if (VECS[v].strobe) last_phys = VECS[v].addr;
      check("R1-4 vec strobe", {31'd0, mem_strobe}, {31'd0, VECS[v].strobe});
      check("R1-4 vec done/abort", {30'd0, acc_done, cyc_abort}, 32'd2);
      check("R1-4 vec phys", phys_addr, last_phys);
    end

    // R6 miss, R9 stall, R7 retry
    access(32'h0012_3456, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 abort", {30'd0, cyc_abort, mem_strobe}, 32'd2);
    check("R6 req", {31'd0, walk_req}, 32'd1);
    check("R6 vpn", {12'd0, walk_vpn}, 32'h0000_0123);
    check("R6 fc", {29'd0, walk_fc}, 32'd5);
    check("R9 not ready", {31'd0, acc_ready}, 32'd0);
    access(32'h0000_1000, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 ignored", {29'd0, mem_strobe, acc_done, cyc_abort}, 32'd0);
    serve(20'hABCDE, 1'b0, 2);
    check("R7 retry strobe", {30'd0, mem_strobe, cyc_abort}, 32'd2);
    check("R7 retry phys", phys_addr, 32'hABCD_E456);

    // R5 hits and fc mismatch
    access(32'h0012_3FFF, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 hit", {29'd0, mem_strobe, cyc_abort, walk_req}, 32'd4);
    check("R5 hit phys", phys_addr, 32'hABCD_EFFF);
    access(32'h0012_3010, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 fc mismatch miss", {31'd0, cyc_abort}, 32'd1);
    serve(20'h11111, 1'b0, 0);
    check("R5 second mapping", phys_addr, 32'h1111_1010);
    access(32'h0012_3020, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 first mapping kept", phys_addr, 32'hABCD_E020);

    // R4 window beats a cached mapping
    access(32'h0012_3456, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 over cache", phys_addr, 32'h0012_3456);

    // R8 bus error entry
    access(32'h0777_7000, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    serve(20'h00042, 1'b1, 1);
    check("R8 retry exc", {28'd0, mem_strobe, cyc_abort, berr_exc, acc_done}, 32'd7);
    access(32'h0777_7004, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 rehit exc", {28'd0, mem_strobe, cyc_abort, berr_exc, acc_done}, 32'd7);
    check("R8 no walk", {31'd0, walk_req}, 32'd0);

    // R10 flush
    pulse_flush();
    access(32'h0012_3456, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 miss after flush", {31'd0, cyc_abort}, 32'd1);
    serve(20'h33333, 1'b0, 0);

    // R11 replacement
    pulse_flush();
    for (int i = 0; i < 9; i++) begin
      access({20'h00100 + 20'(i), 12'h008}, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R11 fill miss", {31'd0, cyc_abort}, 32'd1);
      serve(20'h00200 + 20'(i), 1'b0, 0);
      check("R11 fill phys", phys_addr, {20'h00200 + 20'(i), 12'h008});
    end
    access(32'h0010_1044, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 survivor hit", {30'd0, mem_strobe, cyc_abort}, 32'd2);
    check("R11 survivor phys", phys_addr, 32'h0020_1044);
    access(32'h0010_8000, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 newest hit", phys_addr, 32'h0020_8000);
    access(32'h0010_0000, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 evicted slot0 miss", {31'd0, cyc_abort}, 32'd1);
    serve(20'h00300, 1'b0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule